// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Front End

This block is the digital front end of an 8-bit parallel-input digital-to-analog converter. A host drives an 8-bit bus together with active-low chip-select, write, load and clear strobes. The strobes are asynchronous to the system clock. Each one is passed through a synchronizer and an edge detector. A qualified write stores the bus in an input register. A second register, the DAC register, holds the code that is actually converted. Both halves of that code are expanded into thermometer lines that drive the converter's segment switches.

The level of the load strobe at the end of each write selects the update mode. If load is low, the DAC register takes the new code at that same write edge. If load is high, the update is held back until the next falling edge of load. This lets several converters change their outputs together. A status bit shows that a held-back update is waiting. A sticky flag reports the case where a new write ends while the load pulse that applied a held-back update is still low.

An active-low power-on strobe resets every flop asynchronously. An active-low clear input empties both registers while it is held low.

Top module: `pdac_frontend`

## Requirements
- R1: While ponN is low, all flops are reset asynchronously. dacCode and both thermometer outputs are zero, and deferPending and protoErr are 0.
- R2: A write completes when wrN rises while csN is low and clrN is high. If ldacN is low at that moment, dacCode shows the bus value that was present at that wrN rising edge. The new code appears 3 clock cycles after the edge and is not yet visible after 2 cycles.
- R3: A wrN rising edge while csN is high leaves dacCode and deferPending unchanged.
- R4: A completed write with ldacN high stores the bus in the input register only. dacCode is unchanged and deferPending becomes 1.
- R5: While an update is pending, a falling edge of ldacN copies the input register into dacCode 3 cycles later and clears deferPending.
- R6: If two writes with ldacN high complete before a load edge, the later bus value is the one applied at the load edge.
- R7: A falling edge of ldacN with nothing pending leaves dacCode unchanged.
- R8: If a write completes while ldacN is still low from the falling edge that applied a pending update, protoErr becomes 1 and the write is applied immediately. protoErr stays 1 until clear or power-on reset.
- R9: While clrN is low, dacCode, the input register, deferPending and protoErr are zero, and writes have no effect. This takes hold 3 cycles after clrN falls. Normal operation resumes once clrN is high again.
- R10: upperTherm is the thermometer code of dacCode[7:4] and lowerTherm is the thermometer code of dacCode[3:0]. For a nibble value n, bits n-1 down to 0 are set and all other bits are clear, so 0 gives no bits set and 15 gives all 15 bits set.
- R11: A change on dataIn after the wrN rising edge does not alter the captured code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ponN | input | 1 | Active-low power-on strobe, asynchronous reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe; its rising edge completes a write |
| ldacN | input | 1 | Active-low load strobe; its level selects the mode, and its falling edge applies a pending update |
| clrN | input | 1 | Active-low clear, level sensitive |
| dataIn | input | 8 | Parallel data bus |
| dacCode | output | 8 | Contents of the DAC register |
| upperTherm | output | 15 | Thermometer code of the upper nibble |
| lowerTherm | output | 15 | Thermometer code of the lower nibble |
| deferPending | output | 1 | A held-back update is waiting for a load edge |
| protoErr | output | 1 | Sticky flag: a write ended during an active load pulse |

## Verification
Every strobe-driven result appears 3 clock cycles after the host edge. The edge takes two synchronizer flops and then one register load. The one exception is the power-on strobe, which acts at once. The bench changes its inputs on falling clock edges and reads the outputs on the third falling edge after the stimulus edge, when each register has settled. One directed test also reads dacCode on the second falling edge, to show that the new code has not yet arrived and that the latency is not shorter than stated.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int DATA_W      = 8;
  localparam int NIB_W       = 4;
  localparam int NUM_NIB     = DATA_W / NIB_W;
  localparam int THERM_W     = (1 << NIB_W) - 1;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_STROBES = 4;
  // strobe positions inside the synchronized vector
  localparam int IDX_CS  = 0;
  localparam int IDX_WR  = 1;
  localparam int IDX_LD  = 2;
  localparam int IDX_CLR = 3;

  typedef struct packed {
    logic clearAll;        // clear both registers
    logic loadInput;       // qualified write: capture bus into input register
    logic loadDacAuto;     // write with load low: DAC register takes the bus too
    logic loadDacDeferred; // load falling edge: DAC register takes input register
  } pdac_strobe_t;
endpackage

// File: rtl/pdac_therm.sv
module pdac_therm #(
  parameter int NIB_W   = 4,
  parameter int THERM_W = (1 << NIB_W) - 1
) (
  input  logic [NIB_W-1:0]   level,
  output logic [THERM_W-1:0] therm
);
  for (genvar g = 0; g < THERM_W; g++) begin : g_line
    assign therm[g] = (32'(level) > g);
  end
endmodule

// File: rtl/pdac_ctrl.sv
module pdac_ctrl import pdac_pkg::*; (
  input  logic                   clk,
  input  logic                   ponN,
  input  logic [NUM_STROBES-1:0] rawStrobeN,
  output pdac_strobe_t           strobe,
  output logic                   deferPending,
  output logic                   protoErr
);
  logic [NUM_STROBES-1:0] syncStage [SYNC_STAGES];
  logic [NUM_STROBES-1:0] syncLvl;
  logic prevWr, prevLdac;
  logic loadLowActive;
  logic wrRise, ldacFall, ldacRise;
  logic clrActive, validWrite, autoLoad, deferArm, deferredLoad;

  // synchronizer chain, idle level is high for every strobe
  always_ff @(posedge clk or negedge ponN) begin
    if (!ponN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '1;
      prevWr   <= 1'b1;
      prevLdac <= 1'b1;
    end else begin
      syncStage[0] <= rawStrobeN;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      prevWr   <= syncLvl[IDX_WR];
      prevLdac <= syncLvl[IDX_LD];
    end
  end

  assign syncLvl  = syncStage[SYNC_STAGES-1];
  assign wrRise   = syncLvl[IDX_WR] & ~prevWr;
  assign ldacFall = ~syncLvl[IDX_LD] & prevLdac;
  assign ldacRise = syncLvl[IDX_LD] & ~prevLdac;

  assign clrActive    = ~syncLvl[IDX_CLR];
  assign validWrite   = wrRise & ~syncLvl[IDX_CS] & ~clrActive;
  assign autoLoad     = validWrite & ~syncLvl[IDX_LD];
  assign deferArm     = validWrite & syncLvl[IDX_LD];
  assign deferredLoad = ldacFall & deferPending & ~validWrite & ~clrActive;

  always_comb begin
    strobe                 = '0;
    strobe.clearAll        = clrActive;
    strobe.loadInput       = validWrite;
    strobe.loadDacAuto     = autoLoad;
    strobe.loadDacDeferred = deferredLoad;
  end

  // mode and protocol state
  always_ff @(posedge clk or negedge ponN) begin
    if (!ponN) begin
      deferPending  <= 1'b0;
      loadLowActive <= 1'b0;
      protoErr      <= 1'b0;
    end else if (clrActive) begin
      deferPending  <= 1'b0;
      loadLowActive <= 1'b0;
      protoErr      <= 1'b0;
    end else begin
      if (deferArm)                          deferPending <= 1'b1;
      else if (autoLoad || deferredLoad)     deferPending <= 1'b0;

      if (deferredLoad)                      loadLowActive <= 1'b1;
      else if (ldacRise)                     loadLowActive <= 1'b0;

      if (validWrite && loadLowActive)       protoErr <= 1'b1;
    end
  end

  // R4
  arm_sets_pending_chk: assert property (@(posedge clk) disable iff (!ponN)
    (strobe.loadInput && !strobe.loadDacAuto) |=> deferPending);

  // R5
  load_clears_pending_chk: assert property (@(posedge clk) disable iff (!ponN)
    strobe.loadDacDeferred |=> !deferPending);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!ponN)
    protoErr |=> (protoErr || $past(clrActive)));

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!ponN)
    strobe.clearAll |=> (!deferPending && !protoErr));
endmodule

// File: rtl/pdac_datapath.sv
module pdac_datapath import pdac_pkg::*; (
  input  logic                              clk,
  input  logic                              ponN,
  input  logic [DATA_W-1:0]                 dataIn,
  input  pdac_strobe_t                      strobe,
  output logic [DATA_W-1:0]                 dacCode,
  output logic [NUM_NIB-1:0][THERM_W-1:0]   thermOut
);
  logic [DATA_W-1:0] dataPipe [SYNC_STAGES];
  logic [DATA_W-1:0] capData;
  logic [DATA_W-1:0] inputReg;
  logic [DATA_W-1:0] dacReg;

  // bus delayed alongside the strobes so the value at the write edge is kept
  always_ff @(posedge clk or negedge ponN) begin
    if (!ponN) begin
      for (int s = 0; s < SYNC_STAGES; s++) dataPipe[s] <= '0;
    end else begin
      dataPipe[0] <= dataIn;
      for (int s = 1; s < SYNC_STAGES; s++) dataPipe[s] <= dataPipe[s-1];
    end
  end

  assign capData = dataPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge ponN) begin
    if (!ponN) begin
      inputReg <= '0;
      dacReg   <= '0;
    end else if (strobe.clearAll) begin
      inputReg <= '0;
      dacReg   <= '0;
    end else begin
      if (strobe.loadInput)            inputReg <= capData;
      if (strobe.loadDacAuto)          dacReg   <= capData;
      else if (strobe.loadDacDeferred) dacReg   <= inputReg;
    end
  end

  assign dacCode = dacReg;

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    pdac_therm #(.NIB_W(NIB_W), .THERM_W(THERM_W)) i_therm (
      .level (dacReg[n*NIB_W +: NIB_W]),
      .therm (thermOut[n])
    );
    // R10
    therm_count_chk: assert property (@(posedge clk) disable iff (!ponN)
      $countones(thermOut[n]) == 32'(dacReg[n*NIB_W +: NIB_W]));
  end

  // R2
  auto_match_chk: assert property (@(posedge clk) disable iff (!ponN)
    (strobe.loadDacAuto && !strobe.clearAll) |=> (dacReg == inputReg));

  // R9
  clear_regs_chk: assert property (@(posedge clk) disable iff (!ponN)
    strobe.clearAll |=> (dacReg == '0 && inputReg == '0));

  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!ponN)
    !(strobe.loadDacAuto || strobe.loadDacDeferred || strobe.clearAll) |=> $stable(dacReg));
endmodule

// File: rtl/pdac_frontend.sv
module pdac_frontend import pdac_pkg::*; (
  input  logic               clk,
  input  logic               ponN,
  input  logic               csN,
  input  logic               wrN,
  input  logic               ldacN,
  input  logic               clrN,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [DATA_W-1:0]  dacCode,
  output logic [THERM_W-1:0] upperTherm,
  output logic [THERM_W-1:0] lowerTherm,
  output logic               deferPending,
  output logic               protoErr
);
  logic [NUM_STROBES-1:0]            rawStrobeN;
  pdac_strobe_t                      strobe;
  logic [NUM_NIB-1:0][THERM_W-1:0]   thermOut;

  always_comb begin
    rawStrobeN          = '1;
    rawStrobeN[IDX_CS]  = csN;
    rawStrobeN[IDX_WR]  = wrN;
    rawStrobeN[IDX_LD]  = ldacN;
    rawStrobeN[IDX_CLR] = clrN;
  end

  pdac_ctrl i_ctrl (
    .clk          (clk),
    .ponN         (ponN),
    .rawStrobeN   (rawStrobeN),
    .strobe       (strobe),
    .deferPending (deferPending),
    .protoErr     (protoErr)
  );

  pdac_datapath i_datapath (
    .clk      (clk),
    .ponN     (ponN),
    .dataIn   (dataIn),
    .strobe   (strobe),
    .dacCode  (dacCode),
    .thermOut (thermOut)
  );

  assign upperTherm = thermOut[1];
  assign lowerTherm = thermOut[0];
endmodule

// File: tb/test_pdac_frontend.sv
module test_pdac_frontend;
  logic clk = 1'b0;
  logic ponN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, ldacN = 1'b1, clrN = 1'b1;
  logic [7:0]  dataIn = 8'h00;
  logic [7:0]  dacCode;
  logic [14:0] upperTherm, lowerTherm;
  logic deferPending, protoErr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pdac_frontend i_pdac_frontend (
    .clk(clk), .ponN(ponN), .csN(csN), .wrN(wrN), .ldacN(ldacN), .clrN(clrN),
    .dataIn(dataIn), .dacCode(dacCode), .upperTherm(upperTherm),
    .lowerTherm(lowerTherm), .deferPending(deferPending), .protoErr(protoErr)
  );

  localparam logic [1:0] OP_AUTO = 2'd0, OP_DEFER = 2'd1, OP_CSOFF = 2'd2, OP_LOAD = 2'd3;
  localparam int NVEC = 14;
  // {op, bus value, expected dacCode, expected pending}
  localparam logic [18:0] VEC [NVEC] = '{
    {OP_AUTO,  8'h5A, 8'h5A, 1'b0},  // R2
    {OP_AUTO,  8'hF0, 8'hF0, 1'b0},  // R2
    {OP_CSOFF, 8'h33, 8'hF0, 1'b0},  // R3
    {OP_DEFER, 8'h81, 8'hF0, 1'b1},  // R4
    {OP_LOAD,  8'h00, 8'h81, 1'b0},  // R5
    {OP_LOAD,  8'h00, 8'h81, 1'b0},  // R7
    {OP_DEFER, 8'h0F, 8'h81, 1'b1},  // R4
    {OP_DEFER, 8'hC3, 8'h81, 1'b1},  // R6
    {OP_LOAD,  8'h00, 8'hC3, 1'b0},  // R6
    {OP_AUTO,  8'hFF, 8'hFF, 1'b0},  // R10 all lines
    {OP_AUTO,  8'h00, 8'h00, 1'b0},  // R10 no lines
    {OP_DEFER, 8'h7E, 8'h00, 1'b1},  // R4
    {OP_CSOFF, 8'h11, 8'h00, 1'b1},  // R3 with pending
    {OP_LOAD,  8'h00, 8'h7E, 1'b0}   // R5
  };

  function automatic logic [14:0] thermOf(input logic [3:0] n);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = (i < int'(n));
    return r;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic checkOut(input string req, input logic [7:0] expCode,
                          input logic expPend, input logic expErr);
    checks++;
    if (dacCode !== expCode || upperTherm !== thermOf(expCode[7:4]) ||
        lowerTherm !== thermOf(expCode[3:0]) || deferPending !== expPend ||
        protoErr !== expErr) begin
      errors++;
      $display("FAIL %s: code=%h up=%h lo=%h pend=%b err=%b expected code=%h up=%h lo=%h pend=%b err=%b",
               req, dacCode, upperTherm, lowerTherm, deferPending, protoErr,
               expCode, thermOf(expCode[7:4]), thermOf(expCode[3:0]), expPend, expErr);
    end
  endtask

  // write cycle; returns on the third falling edge after wrN rises
  task automatic doWrite(input logic [7:0] d, input logic ldLvl, input logic csLvl,
                         input logic spoil, input logic [7:0] spoilVal,
                         input logic [7:0] earlyExp);
    @(negedge clk);
    csN = csLvl; dataIn = d; ldacN = ldLvl; wrN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    csN = 1'b1; ldacN = 1'b1;
    if (spoil) dataIn = spoilVal;
    @(negedge clk);
    if (spoil) begin
      // R2 latency: new code not yet visible two cycles after the edge
      checks++;
      if (dacCode !== earlyExp) begin
        errors++;
        $display("FAIL R2 early: code=%h expected=%h", dacCode, earlyExp);
      end
    end
    @(negedge clk);
  endtask

  task automatic pulseLoad(input logic release_);
    @(negedge clk);
    ldacN = 1'b0;
    repeat (3) @(negedge clk);
    if (release_) ldacN = 1'b1;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 reset", 8'h00, 1'b0, 1'b0);
    ponN = 1'b1;
    repeat (4) @(negedge clk);
    checkOut("R1 after release", 8'h00, 1'b0, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op;
      op = VEC[v][18:17];
      case (op)
        OP_AUTO:  doWrite(VEC[v][16:9], 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        OP_DEFER: doWrite(VEC[v][16:9], 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        OP_CSOFF: doWrite(VEC[v][16:9], 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        default:  pulseLoad(1'b0);
      endcase
      checkOut($sformatf("R2-table vec %0d", v), VEC[v][8:1], VEC[v][0], 1'b0);
      if (op == OP_LOAD) begin
        ldacN = 1'b1;
        repeat (4) @(negedge clk);
      end
    end

    // R11: bus changes right after the write edge; also R2 latency
    doWrite(8'h2C, 1'b0, 1'b0, 1'b1, 8'hD5, 8'h7E);
    checkOut("R11 capture at edge", 8'h2C, 1'b0, 1'b0);

    // R8: write while the applying load pulse is still low
    doWrite(8'h44, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    pulseLoad(1'b0);
    checkOut("R8 deferred applied", 8'h44, 1'b0, 1'b0);
    doWrite(8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    checkOut("R8 error raised", 8'h99, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    checkOut("R8 error sticky", 8'h99, 1'b0, 1'b1);

    // R9: clear
    clrN = 1'b0;
    repeat (3) @(negedge clk);
    checkOut("R9 clear", 8'h00, 1'b0, 1'b0);
    doWrite(8'h66, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    checkOut("R9 write ignored in clear", 8'h00, 1'b0, 1'b0);
    doWrite(8'h77, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    checkOut("R9 no arm in clear", 8'h00, 1'b0, 1'b0);
    clrN = 1'b1;
    repeat (4) @(negedge clk);
    pulseLoad(1'b1);
    repeat (4) @(negedge clk);
    checkOut("R9 input register emptied", 8'h00, 1'b0, 1'b0);
    doWrite(8'h12, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    checkOut("R9 resume", 8'h12, 1'b0, 1'b0);

    // R1: power-on strobe mid-run
    doWrite(8'h55, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    checkOut("R4 arm before pon", 8'h12, 1'b1, 1'b0);
    @(negedge clk);
    ponN = 1'b0;
    #1;
    checkOut("R1 async pon", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    ponN = 1'b1;
    repeat (3) @(negedge clk);
    doWrite(8'h3C, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    checkOut("R10 after pon", 8'h3C, 1'b0, 1'b0);

    finishRun();
  end
endmodule